// File: doc/BRIEF.md
# Multi-Mode Switching-Converter PWM Pair Generator

This block produces one high-side/low-side pair of gate-drive pulses for a switch-mode power stage. Its own counter sets the switching period. A compare of the counter against an on-time value shapes each pulse. An optional phase offset shifts the pulse within the period when the block runs phase-aligned with other copies of itself. Each copy has its own time base, so separate pairs can run at separate frequencies.

Period, on-time and phase are written as a group with a load strobe into holding registers. The working copies take them at the next period boundary, so a cycle never runs on a half-updated value. In variable-phase operation the phase is taken at once. A live mode select picks one of seven behaviours:
- identical outputs;
- an inverted low side;
- pulses alternating between the two sides;
- phase-shifted multi-unit operation with a shared sync;
- the same with a live phase;
- comparator-ended off-time, where the frequency varies;
- comparator-ended on-time, which gives cycle-by-cycle current limiting.

Top module: `pwm_pair_gen`

## Requirements
- R1: While reset is held, pwm_hi and pwm_lo are 0 and sync_out is 1 (counter at zero).
- R2: The counter counts 0 to period-1 and then restarts. sync_out is 1 in exactly one cycle per period: the cycle in which the counter is zero.
- R3: cfg_mode=0 (identical): pwm_hi is high for `duty` cycles of each period, starting at counter zero. pwm_lo equals pwm_hi when en_lo=1 and stays 0 when en_lo=0. Each output reflects the counter value of the previous cycle.
- R4: cfg_mode=1 (inverted): pwm_lo is the inverse of pwm_hi. pwm_lo is also the inverse of pwm_hi in modes 3 to 6.
- R5: cfg_mode=2 (alternating): the pulse goes to pwm_hi in one period and to pwm_lo in the next, and the two outputs are never high together.
- R6: A duty of 0 keeps the pulse off. A duty at or above the period keeps it on for the whole period.
- R7: A cfg_load pulse stores period, duty and phase into holding registers. Period and duty reach the working registers only at a period restart.
- R8: cfg_mode=3 (multi-phase): sync_in forces a restart, and the pulse starts `phase` cycles after counter zero. A phase written mid-period takes effect only from the next restart.
- R9: cfg_mode=4 (variable phase): as mode 3, but a newly loaded phase takes effect within two cycles, while the period is running.
- R10: cfg_mode=5 (off-time end): cmp_in during the off-time (counter >= duty) restarts the period on the next cycle. cmp_in during the on-time is ignored. Without cmp_in the period restarts at `period` cycles.
- R11: cfg_mode=6 (on-time end): cmp_in ends the pulse, so pwm_hi is 0 from the next cycle. The pulse stays off until the next period starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 3 | Mode select, 0 to 6 |
| cfg_period | input | CNT_W | Period in clocks (timeout in mode 5) |
| cfg_duty | input | CNT_W | On-time in clocks |
| cfg_phase | input | CNT_W | Phase offset in clocks (modes 3, 4) |
| cfg_load | input | 1 | Stores cfg_period/duty/phase into holding registers |
| en_lo | input | 1 | Enables pwm_lo in mode 0 |
| sync_in | input | 1 | Forces restart in modes 3, 4 |
| cmp_in | input | 1 | Comparator / external trip input |
| pwm_hi | output | 1 | High-side drive |
| pwm_lo | output | 1 | Low-side drive |
| sync_out | output | 1 | High while the counter is zero |

## Verification
On every cycle, the checker confirms that the inverted output is the complement of the high side and that the alternating outputs never overlap. It also confirms that a trip in on-time-end mode forces the high side low on the next cycle, that a zero on-time never yields a pulse, and that the working on-time changes only at a restart. The bench's scenarios show the rest: pulse totals per window for each mode, the period shortened by a comparator, the trip being ignored during the on-time, and the exact cycle at which a phase-shifted pulse first rises after a sync or after a live phase change.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [2:0] {
    MODE_STD      = 3'd0,
    MODE_COMP     = 3'd1,
    MODE_PUSHPULL = 3'd2,
    MODE_MULTIPH  = 3'd3,
    MODE_VARPH    = 3'd4,
    MODE_CURRST   = 3'd5,
    MODE_CURLIM   = 3'd6
  } pwm_mode_e;
endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rs_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rs_n = chain_q[STAGES-1];
endmodule

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rs_n,
  input  logic             cfg_load,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_duty,
  input  logic [CNT_W-1:0] cfg_phase,
  input  logic             restart,
  input  logic             live_phase,
  output logic [CNT_W-1:0] per_act,
  output logic [CNT_W-1:0] duty_act,
  output logic [CNT_W-1:0] ph_act
);
  logic [CNT_W-1:0] per_sh_q, duty_sh_q, ph_sh_q;
  logic [CNT_W-1:0] per_sh_d, duty_sh_d, ph_sh_d;
  logic [CNT_W-1:0] per_d, duty_d, ph_d;
  logic             ph_en;

  always_comb begin
    per_sh_d  = per_sh_q;
    duty_sh_d = duty_sh_q;
    ph_sh_d   = ph_sh_q;
    if (cfg_load) begin
      per_sh_d  = cfg_period;
      duty_sh_d = cfg_duty;
      ph_sh_d   = cfg_phase;
    end
    ph_en  = restart | live_phase;
    per_d  = restart ? per_sh_q  : per_act;
    duty_d = restart ? duty_sh_q : duty_act;
    ph_d   = ph_en   ? ph_sh_q   : ph_act;
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      per_sh_q  <= '0;
      duty_sh_q <= '0;
      ph_sh_q   <= '0;
      per_act   <= '0;
      duty_act  <= '0;
      ph_act    <= '0;
    end else begin
      per_sh_q  <= per_sh_d;
      duty_sh_q <= duty_sh_d;
      ph_sh_q   <= ph_sh_d;
      per_act   <= per_d;
      duty_act  <= duty_d;
      ph_act    <= ph_d;
    end
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rs_n,
  input  logic [CNT_W-1:0] per_act,
  input  logic [CNT_W-1:0] duty_act,
  input  logic             sync_req,
  input  logic             cr_mode,
  input  logic             cmp_in,
  output logic [CNT_W-1:0] cnt,
  output logic             restart
);
  localparam int CW1 = CNT_W + 1;

  logic [CNT_W-1:0] cnt_d;
  logic             last, off_end;

  always_comb begin
    last    = ({1'b0, cnt} + CW1'(1)) >= {1'b0, per_act};
    off_end = cr_mode && cmp_in && (cnt >= duty_act);
    restart = last | off_end | sync_req;
    cnt_d   = restart ? '0 : cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) cnt <= '0;
    else       cnt <= cnt_d;
  end
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rs_n,
  input  pwm_pkg::pwm_mode_e mode,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] per_act,
  input  logic [CNT_W-1:0] duty_act,
  input  logic [CNT_W-1:0] ph_act,
  input  logic             restart,
  input  logic             cmp_in,
  input  logic             en_lo,
  output logic             pwm_hi,
  output logic             pwm_lo
);
  import pwm_pkg::*;

  logic [CNT_W:0] pos;
  logic           use_phase, cl_mode, raw_on, pulse;
  logic           trunc_q, trunc_d, sel_q, sel_d, hi_d, lo_d;

  always_comb begin
    use_phase = (mode == MODE_MULTIPH) || (mode == MODE_VARPH);
    cl_mode   = (mode == MODE_CURLIM);
    if (use_phase) begin
      if (cnt >= ph_act) pos = {1'b0, cnt} - {1'b0, ph_act};
      else               pos = {1'b0, cnt} + {1'b0, per_act} - {1'b0, ph_act};
    end else begin
      pos = {1'b0, cnt};
    end
    raw_on = (duty_act != '0) &&
             ((duty_act >= per_act) || (pos < {1'b0, duty_act}));
    pulse  = raw_on && !trunc_q && !(cl_mode && cmp_in);

    trunc_d = trunc_q;
    if (restart)                trunc_d = 1'b0;
    else if (cl_mode && cmp_in) trunc_d = 1'b1;

    sel_d = restart ? !sel_q : sel_q;

    case (mode)
      MODE_STD: begin
        hi_d = pulse;
        lo_d = pulse && en_lo;
      end
      MODE_PUSHPULL: begin
        hi_d = pulse && !sel_q;
        lo_d = pulse && sel_q;
      end
      default: begin
        hi_d = pulse;
        lo_d = !pulse;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      trunc_q <= 1'b0;
      sel_q   <= 1'b0;
      pwm_hi  <= 1'b0;
      pwm_lo  <= 1'b0;
    end else begin
      trunc_q <= trunc_d;
      sel_q   <= sel_d;
      pwm_hi  <= hi_d;
      pwm_lo  <= lo_d;
    end
  end
endmodule

// File: rtl/pwm_pair_gen.sv
module pwm_pair_gen #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cfg_mode,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_duty,
  input  logic [CNT_W-1:0] cfg_phase,
  input  logic             cfg_load,
  input  logic             en_lo,
  input  logic             sync_in,
  input  logic             cmp_in,
  output logic             pwm_hi,
  output logic             pwm_lo,
  output logic             sync_out
);
  import pwm_pkg::*;

  pwm_mode_e        mode;
  logic             rs_n, restart, sync_req, cr_mode, live_phase;
  logic [CNT_W-1:0] cnt, per_act, duty_act, ph_act;

  always_comb begin
    mode       = pwm_mode_e'(cfg_mode);
    sync_req   = sync_in && ((mode == MODE_MULTIPH) || (mode == MODE_VARPH));
    cr_mode    = (mode == MODE_CURRST);
    live_phase = (mode == MODE_VARPH);
  end

  pwm_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rs_n(rs_n)
  );

  pwm_shadow_regs #(.CNT_W(CNT_W)) u_shadow (
    .clk(clk), .rs_n(rs_n), .cfg_load(cfg_load),
    .cfg_period(cfg_period), .cfg_duty(cfg_duty), .cfg_phase(cfg_phase),
    .restart(restart), .live_phase(live_phase),
    .per_act(per_act), .duty_act(duty_act), .ph_act(ph_act)
  );

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rs_n(rs_n), .per_act(per_act), .duty_act(duty_act),
    .sync_req(sync_req), .cr_mode(cr_mode), .cmp_in(cmp_in),
    .cnt(cnt), .restart(restart)
  );

  pwm_out_stage #(.CNT_W(CNT_W)) u_out (
    .clk(clk), .rs_n(rs_n), .mode(mode), .cnt(cnt), .per_act(per_act),
    .duty_act(duty_act), .ph_act(ph_act), .restart(restart),
    .cmp_in(cmp_in), .en_lo(en_lo), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo)
  );

  assign sync_out = (cnt == '0);
endmodule

// File: rtl/pwm_pair_gen_chk.sv
module pwm_pair_gen_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rs_n,
  input logic [2:0]       mode,
  input logic [CNT_W-1:0] duty_act,
  input logic             restart,
  input logic             cmp_in,
  input logic             pwm_hi,
  input logic             pwm_lo
);
  // R4
  comp_inverse_chk: assert property (@(posedge clk) disable iff (!rs_n)
    ($past(rs_n) && mode == 3'd1 && $past(mode) == 3'd1) |-> (pwm_lo != pwm_hi));

  // R5
  pp_exclusive_chk: assert property (@(posedge clk) disable iff (!rs_n)
    ($past(rs_n) && $past(mode) == 3'd2) |-> !(pwm_hi && pwm_lo));

  // R11
  curlim_cut_chk: assert property (@(posedge clk) disable iff (!rs_n)
    ($past(rs_n) && $past(cmp_in) && $past(mode) == 3'd6) |-> !pwm_hi);

  // R6
  zero_duty_chk: assert property (@(posedge clk) disable iff (!rs_n)
    ($past(rs_n) && $past(duty_act) == '0) |-> !pwm_hi);

  // R7
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rs_n)
    ($past(rs_n) && !$stable(duty_act)) |-> $past(restart));
endmodule

bind pwm_pair_gen pwm_pair_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rs_n(rs_n), .mode(cfg_mode), .duty_act(duty_act),
  .restart(restart), .cmp_in(cmp_in), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo)
);

// File: tb/tb_pwm_pair_gen.sv
`timescale 1ns/1ps
module tb_pwm_pair_gen;
  localparam int W = 8;

  logic         clk, rst_n, cfg_load, en_lo, sync_in, cmp_in;
  logic [2:0]   cfg_mode;
  logic [W-1:0] cfg_period, cfg_duty, cfg_phase;
  logic         pwm_hi, pwm_lo, sync_out;

  pwm_pair_gen #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_period(cfg_period),
    .cfg_duty(cfg_duty), .cfg_phase(cfg_phase), .cfg_load(cfg_load),
    .en_lo(en_lo), .sync_in(sync_in), .cmp_in(cmp_in),
    .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .sync_out(sync_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    string tag;
    int    kind;   // 0: window totals, 1: first rise
    int    len;
    int    first;
    int    e_hi;
    int    e_lo;
    int    e_sync;
  } item_t;

  item_t queue_q[$];
  event  start_ev;
  int    issued = 0, done_cnt = 0;
  int    n_chk = 0, n_bad = 0;
  int    cmp_at = 255;
  bit    finished = 0;

  task automatic report(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // comparator stimulus tied to counter position (counter equals k)
  initial begin
    int k;
    k = 0;
    cmp_in = 1'b0;
    forever begin
      @(negedge clk);
      if (sync_out) k = 0;
      else          k = k + 1;
      cmp_in = (k == cmp_at);
    end
  end

  // monitor
  initial begin
    forever begin
      item_t it;
      int hi_n, lo_n, sy_n, rise;
      @(start_ev);
      it = queue_q.pop_front();
      if (it.kind == 0) begin
        hi_n = 0; lo_n = 0; sy_n = 0;
        for (int i = 0; i < it.len; i++) begin
          @(negedge clk);
          hi_n += int'(pwm_hi);
          lo_n += int'(pwm_lo);
          sy_n += int'(sync_out);
        end
        report(it.tag, "hi cycles", hi_n, it.e_hi);
        if (it.e_lo >= 0)   report(it.tag, "lo cycles", lo_n, it.e_lo);
        if (it.e_sync >= 0) report(it.tag, "sync cycles", sy_n, it.e_sync);
      end else begin
        rise = -1;
        for (int i = 1; i <= 60; i++) begin
          @(negedge clk);
          if (rise < 0 && i >= it.first && pwm_hi) rise = i;
        end
        report(it.tag, "rise cycle", rise, it.e_hi);
      end
      done_cnt++;
    end
  end

  task automatic configure(int mode, int per, int duty, int ph, bit lo_en, int cat);
    @(negedge clk);
    cfg_mode = 3'(mode); cfg_period = W'(per); cfg_duty = W'(duty);
    cfg_phase = W'(ph); en_lo = lo_en; cmp_at = cat; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    repeat (70) @(negedge clk);
  endtask

  task automatic window(string tag, int len, int hi, int lo, int sy);
    item_t it;
    it = '{tag: tag, kind: 0, len: len, first: 0, e_hi: hi, e_lo: lo, e_sync: sy};
    queue_q.push_back(it);
    issued++;
    @(negedge clk);
    ->start_ev;
    wait (done_cnt == issued);
  endtask

  task automatic rise_sync(string tag, int exp);
    item_t it;
    it = '{tag: tag, kind: 1, len: 0, first: 2, e_hi: exp, e_lo: -1, e_sync: -1};
    queue_q.push_back(it);
    issued++;
    @(negedge clk);
    sync_in = 1'b1;
    ->start_ev;
    @(negedge clk);
    sync_in = 1'b0;
    wait (done_cnt == issued);
  endtask

  task automatic rise_live(string tag, int new_ph, int exp);
    item_t it;
    it = '{tag: tag, kind: 1, len: 0, first: 1, e_hi: exp, e_lo: -1, e_sync: -1};
    queue_q.push_back(it);
    issued++;
    @(negedge clk);
    while (!sync_out) @(negedge clk);
    cfg_phase = W'(new_ph);
    cfg_load = 1'b1;
    ->start_ev;
    @(negedge clk);
    cfg_load = 1'b0;
    wait (done_cnt == issued);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_mode = 3'd0; cfg_period = '0; cfg_duty = '0;
    cfg_phase = '0; cfg_load = 1'b0; en_lo = 1'b0; sync_in = 1'b0;
    repeat (4) @(negedge clk);
    report("R1", "pwm_hi in reset", int'(pwm_hi), 0);
    report("R1", "pwm_lo in reset", int'(pwm_lo), 0);
    report("R1", "sync_out in reset", int'(sync_out), 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R3 / R2: identical outputs, period 10, on-time 3
    configure(0, 10, 3, 0, 1'b1, 255);
    window("R3_R2 std lo_en", 50, 15, 15, 5);
    configure(0, 10, 3, 0, 1'b0, 255);
    window("R3 std lo_off", 50, 15, 0, 5);
    // R4
    configure(1, 10, 7, 0, 1'b0, 255);
    window("R4 inverted", 50, 35, 15, 5);
    // R5: 4 periods, 2 on each side
    configure(2, 10, 4, 0, 1'b0, 255);
    window("R5 alternate", 40, 8, 8, 4);
    // R6
    configure(0, 10, 0, 0, 1'b1, 255);
    window("R6 zero duty", 50, 0, 0, 5);
    configure(0, 10, 12, 0, 1'b1, 255);
    window("R6 full duty", 50, 50, 50, 5);
    // R11: trip at counter 3 cuts a 6-cycle pulse to 3; trip at 8 is after the pulse
    configure(6, 10, 6, 0, 1'b0, 3);
    window("R11 cut", 50, 15, 35, 5);
    configure(6, 10, 6, 0, 1'b0, 8);
    window("R11 late trip", 50, 30, 20, 5);
    // R10: trip at 9 shortens period to 10; trip at 2 (on-time) ignored -> timeout 20
    configure(5, 20, 4, 0, 1'b0, 9);
    window("R10 off end", 50, 20, 30, 5);
    configure(5, 20, 4, 0, 1'b0, 2);
    window("R10 on trip ignored", 60, 12, 48, 3);
    // R8: sync, pulse starts 7 after zero -> output high 9 negedges after sync
    configure(3, 20, 5, 7, 1'b0, 255);
    rise_sync("R8 sync phase 7", 9);
    configure(3, 20, 5, 0, 1'b0, 255);
    rise_sync("R8 sync phase 0", 2);
    // R8 / R7: phase loaded mid-period waits for restart (old phase 10 stays)
    configure(3, 20, 3, 10, 1'b0, 255);
    rise_live("R8_R7 deferred phase", 4, 11);
    // R9: live phase change applies within the running period
    configure(4, 20, 3, 10, 1'b0, 255);
    rise_live("R9 live phase", 4, 5);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule